// File: doc/BRIEF.md
# Reset Boot Loading Sequencer

This block decides, right after a synchronous reset, how a small signal-processing core gets its first program image, and keeps the core stalled until that image is in place. Three configuration bits are captured once, on the first rising clock edge at which reset is low. They select one of three flows: a byte-wide DMA load, a host-driven load, or a direct start with no load.

In the byte-wide DMA flow the sequencer sets its transfer registers to their boot values. These are: transfer direction into the core, page 0, internal word address 0, external byte address 0, transfer type "24-bit program words", a count of 32 words and the stall bit set. It then reads bytes one at a time over a request/acknowledge port and packs every three bytes into one program word. It writes the 32 words to program memory at addresses 0 to 31 and then lets the core run from address 0. In the host flow, writes arriving on the host port are passed on to program memory, and the core stays stalled until a write targets program address 0. The flash in the system sits on the byte-wide bus, so the all-zero mode selects the byte-wide DMA flow.

Top module: `boot_loader_top`

## Requirements
- R1: `mode_bits` (bit 2 = C, bit 1 = B, bit 0 = A) is captured on the first rising edge with `rst` low. Any later change of `mode_bits` has no effect on the flow until the next reset.
- R2: Mode 3'b000 selects the byte-DMA flow and mode 3'b101 selects the host flow. Every other value selects no load. In that case `core_hold` is low from the first rising edge after reset release, and `bm_rd` and `pm_we` stay low.
- R3: In the byte-DMA flow, `bm_addr` is {page, external address} and starts at 0. It increases by one for each byte. `bm_rd` is a single-cycle pulse, and the next pulse comes only after `bm_ack` has returned the previous byte.
- R4: Each program word is three consecutive bytes with the first byte fetched in bits 23:16, the second in 15:8 and the third in 7:0. Words are written on `pm_we`/`pm_addr`/`pm_wdata` at addresses 0, 1, 2 and onward.
- R5: The byte-DMA flow writes exactly 32 words from 96 bytes. After that no further `bm_rd` or `pm_we` occurs.
- R6: During reset `core_hold` is 1 and `core_start`, `bm_rd` and `pm_we` are 0. In the byte-DMA flow, `core_hold` falls on the second rising edge after the cycle that presents the 32nd word. `core_hold` never rises again before the next reset. `core_start` is a one-cycle pulse in the first cycle with `core_hold` low, which is when the core begins at address 0.
- R7: In the host flow, a host write sampled at a rising edge appears on the program-memory port in the following cycle. `core_hold` stays 1 until a write to address 0, and falls in the same cycle that this write appears.
- R8: Host-port writes are ignored in the byte-DMA and no-load flows. They produce no `pm_we` and do not release the core.
- R9: In the host flow, host writes after the release are still passed on to program memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_bits | input | 3 | Boot selection {C,B,A}, captured once at reset release |
| bm_rd | output | 1 | Byte read request pulse |
| bm_addr | output | 22 | Byte address {page[7:0], external[13:0]} |
| bm_ack | input | 1 | Byte read data valid |
| bm_rdata | input | 8 | Byte read data |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 14 | Host write program address |
| host_wdata | input | 24 | Host write data |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 14 | Program memory word address |
| pm_wdata | output | 24 | Program memory write data |
| core_hold | output | 1 | Core stall, 1 keeps the core from executing |
| core_start | output | 1 | One-cycle pulse when the core is released at address 0 |

## Verification
The byte-DMA flow is exercised with two byte-content patterns and with read latencies of one and three cycles. This separates errors in byte order and word packing from errors in the request/acknowledge sequencing. A mode change and a host write to address 0 are injected mid-load, which exposes a design that re-reads the mode bits or lets the host port leak into this flow. The host flow interleaves non-zero addresses before the address-0 write, so releasing on any write can be told apart from releasing on address 0. Two different no-load codes confirm that only 3'b000 and 3'b101 start a load.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int BYTE_W         = 8;
    localparam int WORD_W         = 24;
    localparam int PAGE_W         = 8;
    localparam int EXT_W          = 14;
    localparam int PM_ADDR_W      = 14;
    localparam int BM_ADDR_W      = PAGE_W + EXT_W;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int DEF_WORDS      = 32;
    localparam int CNT_W          = $clog2(DEF_WORDS + 1);

    localparam logic [2:0] MODE_BYTE_BUS = 3'b000;
    localparam logic [2:0] MODE_HOST     = 3'b101;

    typedef enum logic [1:0] {
        BOOT_NONE     = 2'd0,
        BOOT_BYTE_DMA = 2'd1,
        BOOT_HOST     = 2'd2
    } boot_kind_e;

    typedef enum logic [1:0] {
        XT_PM24 = 2'd0,
        XT_DM16 = 2'd1,
        XT_DM8H = 2'd2,
        XT_DM8L = 2'd3
    } xfer_type_e;

    typedef struct packed {
        logic                 to_ext;
        logic [PAGE_W-1:0]    page;
        logic [PM_ADDR_W-1:0] int_addr;
        logic [EXT_W-1:0]     ext_addr;
        xfer_type_e           xtype;
        logic [CNT_W-1:0]     words_left;
        logic                 stall_core;
    } dma_regs_t;

    function automatic boot_kind_e decode_mode(input logic [2:0] m);
        case (m)
            MODE_BYTE_BUS: return BOOT_BYTE_DMA;
            MODE_HOST:     return BOOT_HOST;
            default:       return BOOT_NONE;
        endcase
    endfunction

    function automatic dma_regs_t dma_boot_defaults(input logic [CNT_W-1:0] words);
        dma_regs_t r;
        r.to_ext     = 1'b0;
        r.page       = '0;
        r.int_addr   = '0;
        r.ext_addr   = '0;
        r.xtype      = XT_PM24;
        r.words_left = words;
        r.stall_core = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/boot_mode_capture.sv
module boot_mode_capture
    import boot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_bits,
    output logic       launch,
    output boot_kind_e kind_now,
    output boot_kind_e kind_q
);
    logic armed;

    assign launch   = armed && !rst;
    assign kind_now = decode_mode(mode_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b1;
            kind_q <= BOOT_NONE;
        end else if (launch) begin
            armed  <= 1'b0;
            kind_q <= kind_now;
        end
    end
endmodule

// File: rtl/byte_dma_loader.sv
module byte_dma_loader
    import boot_pkg::*;
#(
    parameter int WORDS = DEF_WORDS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    output logic                 bm_rd,
    output logic [BM_ADDR_W-1:0] bm_addr,
    input  logic                 bm_ack,
    input  logic [BYTE_W-1:0]    bm_rdata,
    output logic                 pm_we,
    output logic [PM_ADDR_W-1:0] pm_addr,
    output logic [WORD_W-1:0]    pm_wdata,
    output logic                 done
);
    localparam logic [CNT_W-1:0] WORDS_C   = CNT_W'(WORDS);
    localparam logic [1:0]       LAST_BYTE = 2'(BYTES_PER_WORD - 1);

    typedef enum logic [2:0] {
        LD_IDLE, LD_REQ, LD_WAIT, LD_WRITE, LD_DONE
    } ld_state_e;

    ld_state_e            st;
    dma_regs_t            r;
    logic [WORD_W-1:0]    acc;
    logic [1:0]           bidx;
    logic [BM_ADDR_W-1:0] byte_ptr_next;

    assign bm_rd    = (st == LD_REQ);
    assign bm_addr  = {r.page, r.ext_addr};
    assign pm_we    = (st == LD_WRITE);
    assign pm_addr  = r.int_addr;
    assign pm_wdata = acc;
    assign done     = !r.stall_core;

    assign byte_ptr_next = {r.page, r.ext_addr} + BM_ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LD_IDLE;
            r    <= dma_boot_defaults(WORDS_C);
            acc  <= '0;
            bidx <= '0;
        end else begin
            case (st)
                LD_IDLE: begin
                    if (start && !r.to_ext && r.xtype == XT_PM24) begin
                        st <= LD_REQ;
                    end
                end
                LD_REQ: st <= LD_WAIT;
                LD_WAIT: begin
                    if (bm_ack) begin
                        acc <= {acc[WORD_W-BYTE_W-1:0], bm_rdata};
                        {r.page, r.ext_addr} <= byte_ptr_next;
                        if (bidx == LAST_BYTE) begin
                            bidx <= '0;
                            st   <= LD_WRITE;
                        end else begin
                            bidx <= bidx + 2'd1;
                            st   <= LD_REQ;
                        end
                    end
                end
                LD_WRITE: begin
                    r.int_addr   <= r.int_addr + PM_ADDR_W'(1);
                    r.words_left <= r.words_left - CNT_W'(1);
                    if (r.words_left == CNT_W'(1)) begin
                        r.stall_core <= 1'b0;
                        st           <= LD_DONE;
                    end else begin
                        st <= LD_REQ;
                    end
                end
                default: st <= LD_DONE;
            endcase
        end
    end
endmodule

// File: rtl/host_boot_port.sv
module host_boot_port
    import boot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 host_we,
    input  logic [PM_ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic                 pm_we,
    output logic [PM_ADDR_W-1:0] pm_addr,
    output logic [WORD_W-1:0]    pm_wdata,
    output logic                 zero_hit
);
    assign zero_hit = enable && host_we && (host_addr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_we    <= 1'b0;
            pm_addr  <= '0;
            pm_wdata <= '0;
        end else begin
            pm_we <= enable && host_we;
            if (enable && host_we) begin
                pm_addr  <= host_addr;
                pm_wdata <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/boot_loader_top.sv
module boot_loader_top
    import boot_pkg::*;
#(
    parameter int BOOT_WORDS = DEF_WORDS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           mode_bits,
    output logic                 bm_rd,
    output logic [BM_ADDR_W-1:0] bm_addr,
    input  logic                 bm_ack,
    input  logic [BYTE_W-1:0]    bm_rdata,
    input  logic                 host_we,
    input  logic [PM_ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic                 pm_we,
    output logic [PM_ADDR_W-1:0] pm_addr,
    output logic [WORD_W-1:0]    pm_wdata,
    output logic                 core_hold,
    output logic                 core_start
);
    logic       launch;
    boot_kind_e kind_now;
    boot_kind_e kind_q;

    logic                 dma_we, dma_done, host_fw_we, host_zero;
    logic [PM_ADDR_W-1:0] dma_addr, host_fw_addr;
    logic [WORD_W-1:0]    dma_data, host_fw_data;
    logic                 release_now;

    boot_mode_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .mode_bits(mode_bits),
        .launch   (launch),
        .kind_now (kind_now),
        .kind_q   (kind_q)
    );

    byte_dma_loader #(.WORDS(BOOT_WORDS)) u_dma (
        .clk     (clk),
        .rst     (rst),
        .start   (kind_q == BOOT_BYTE_DMA),
        .bm_rd   (bm_rd),
        .bm_addr (bm_addr),
        .bm_ack  (bm_ack),
        .bm_rdata(bm_rdata),
        .pm_we   (dma_we),
        .pm_addr (dma_addr),
        .pm_wdata(dma_data),
        .done    (dma_done)
    );

    host_boot_port u_host (
        .clk       (clk),
        .rst       (rst),
        .enable    (kind_q == BOOT_HOST),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .pm_we     (host_fw_we),
        .pm_addr   (host_fw_addr),
        .pm_wdata  (host_fw_data),
        .zero_hit  (host_zero)
    );

    always_comb begin
        if (kind_q == BOOT_HOST) begin
            pm_we    = host_fw_we;
            pm_addr  = host_fw_addr;
            pm_wdata = host_fw_data;
        end else begin
            pm_we    = dma_we;
            pm_addr  = dma_addr;
            pm_wdata = dma_data;
        end
    end

    assign release_now = (launch && kind_now == BOOT_NONE)
                       || (kind_q == BOOT_BYTE_DMA && dma_done)
                       || host_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_hold  <= 1'b1;
            core_start <= 1'b0;
        end else begin
            core_start <= 1'b0;
            if (core_hold && release_now) begin
                core_hold  <= 1'b0;
                core_start <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/boot_loader_checker.sv
module boot_loader_checker
    import boot_pkg::*;
#(
    parameter int WORDS = DEF_WORDS
) (
    input logic       clk,
    input logic       rst,
    input logic       launch,
    input boot_kind_e kind_q,
    input logic       bm_rd,
    input logic       pm_we,
    input logic       core_hold,
    input logic       core_start
);
    logic [CNT_W:0] dma_words;

    always_ff @(posedge clk) begin
        if (rst) dma_words <= '0;
        else if (pm_we && kind_q == BOOT_BYTE_DMA) dma_words <= dma_words + 1'b1;
    end

    assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        !launch |=> $stable(kind_q));

    assert_host_no_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        kind_q == BOOT_HOST |-> !bm_rd);

    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        bm_rd |=> !bm_rd);

    assert_word_limit_R5: assert property (@(posedge clk) disable iff (rst)
        dma_words <= (CNT_W+1)'(WORDS));

    assert_no_fetch_after_release_R5: assert property (@(posedge clk) disable iff (rst)
        !core_hold |-> !bm_rd);

    assert_start_on_release_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(core_hold) |-> core_start);

    assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !core_hold |=> !core_hold);
endmodule

bind boot_loader_top boot_loader_checker #(.WORDS(BOOT_WORDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .kind_q    (kind_q),
    .bm_rd     (bm_rd),
    .pm_we     (pm_we),
    .core_hold (core_hold),
    .core_start(core_start)
);

// File: tb/sim_boot_loader_top.sv
`timescale 1ns/1ps
module sim_boot_loader_top;
    import boot_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [2:0]           mode_bits = 3'b000;
    logic                 bm_rd;
    logic [BM_ADDR_W-1:0] bm_addr;
    logic                 bm_ack = 1'b0;
    logic [BYTE_W-1:0]    bm_rdata = '0;
    logic                 host_we = 1'b0;
    logic [PM_ADDR_W-1:0] host_addr = '0;
    logic [WORD_W-1:0]    host_wdata = '0;
    logic                 pm_we;
    logic [PM_ADDR_W-1:0] pm_addr;
    logic [WORD_W-1:0]    pm_wdata;
    logic                 core_hold;
    logic                 core_start;

    always #2.5 clk = ~clk;

    boot_loader_top u0 (
        .clk(clk), .rst(rst), .mode_bits(mode_bits),
        .bm_rd(bm_rd), .bm_addr(bm_addr), .bm_ack(bm_ack), .bm_rdata(bm_rdata),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .core_hold(core_hold), .core_start(core_start)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int e0_cyc = 0;
    int lat    = 1;
    int seed   = 0;
    int exp_baddr = 0;
    int bytes_served = 0;
    int words_seen = 0;
    int last_write_cyc = -1;
    int hold_fall_cyc = -1;
    int start_cnt = 0;
    int start_cyc = -1;
    logic hold_prev = 1'b1;
    logic [PM_ADDR_W+WORD_W-1:0] exp_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input int a);
        return 8'((a * 37 + seed) ^ (a >> 2));
    endfunction

    // byte memory model with programmable latency
    initial begin
        forever begin
            @(negedge clk);
            bm_ack = 1'b0;
            if (!rst && bm_rd) begin
                int a;
                a = int'(bm_addr);
                check(a == exp_baddr, "R3", "byte address", a, exp_baddr);
                exp_baddr++;
                bytes_served++;
                repeat (lat) @(negedge clk);
                bm_ack   = 1'b1;
                bm_rdata = byte_at(a);
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (pm_we) begin
                    words_seen++;
                    last_write_cyc = cyc;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected program write", {pm_addr, pm_wdata}, 0);
                    end else begin
                        logic [PM_ADDR_W+WORD_W-1:0] e;
                        e = exp_q.pop_front();
                        check({pm_addr, pm_wdata} == e, "R4", "program write {addr,data}",
                              {pm_addr, pm_wdata}, e);
                    end
                end
                if (hold_prev && !core_hold) hold_fall_cyc = cyc;
                if (core_start) begin
                    start_cnt++;
                    start_cyc = cyc;
                end
                hold_prev = core_hold;
            end else begin
                hold_prev = core_hold;
            end
        end
    end

    task automatic boot_reset(input logic [2:0] m);
        rst = 1'b1;
        mode_bits = m;
        exp_baddr = 0; bytes_served = 0; words_seen = 0;
        last_write_cyc = -1; hold_fall_cyc = -1; start_cnt = 0; start_cyc = -1;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(core_hold == 1'b1, "R6", "hold in reset", core_hold, 1);
        check(core_start == 1'b0 && pm_we == 1'b0 && bm_rd == 1'b0, "R6",
              "start/we/rd in reset", {core_start, pm_we, bm_rd}, 0);
        rst = 1'b0;
        @(posedge clk);
        #1 e0_cyc = cyc;
    endtask

    task automatic host_write(input int a, input int d, input bit expect_fw);
        @(negedge clk);
        host_we = 1'b1;
        host_addr = PM_ADDR_W'(a);
        host_wdata = WORD_W'(d);
        if (expect_fw) exp_q.push_back({PM_ADDR_W'(a), WORD_W'(d)});
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run_byte_boot(input int s, input int l);
        seed = s;
        lat  = l;
        boot_reset(3'b000);
        for (int w = 0; w < 32; w++) begin
            exp_q.push_back({PM_ADDR_W'(w),
                             byte_at(3*w), byte_at(3*w+1), byte_at(3*w+2)});
        end
        repeat (5) @(negedge clk);
        mode_bits = 3'b101;                 // R1: change after capture
        host_write(0, 24'h123456, 1'b0);    // R8: ignored in this flow
        for (int i = 0; i < 5000 && words_seen < 32; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(words_seen == 32, "R5", "word count", words_seen, 32);
        check(bytes_served == 96, "R5", "bytes fetched", bytes_served, 96);
        check(exp_q.size() == 0, "R4", "words left unmatched", exp_q.size(), 0);
        check(hold_fall_cyc == last_write_cyc + 2, "R6", "hold fall cycle",
              hold_fall_cyc, last_write_cyc + 2);
        check(start_cnt == 1 && start_cyc == hold_fall_cyc, "R6", "start pulse",
              start_cnt, 1);
        check(core_hold == 1'b0, "R1", "released despite mode change", core_hold, 0);
    endtask

    task automatic run_no_boot(input logic [2:0] m);
        boot_reset(m);
        host_write(0, 24'hABCDEF, 1'b0);    // R8
        repeat (20) @(negedge clk);
        check(hold_fall_cyc == e0_cyc, "R2", "no-load release cycle", hold_fall_cyc, e0_cyc);
        check(start_cnt == 1, "R2", "start pulses", start_cnt, 1);
        check(bytes_served == 0 && words_seen == 0, "R2", "no fetch/write",
              bytes_served + words_seen, 0);
    endtask

    initial begin
        // byte-DMA flow, two contents and latencies
        run_byte_boot(8'h5A, 1);
        run_byte_boot(8'hC3, 3);

        // host flow
        boot_reset(3'b101);
        repeat (2) @(negedge clk);
        mode_bits = 3'b000;                 // R1: must not start a byte load
        host_write(5, 24'h111111, 1'b1);
        host_write(12, 24'h222222, 1'b1);
        host_write(1, 24'h333333, 1'b1);
        repeat (3) @(negedge clk);
        check(core_hold == 1'b1, "R7", "held before address 0", core_hold, 1);
        check(bytes_served == 0, "R2", "host flow fetches no bytes", bytes_served, 0);
        host_write(0, 24'h444444, 1'b1);
        repeat (3) @(negedge clk);
        check(hold_fall_cyc == last_write_cyc, "R7", "release with address 0 write",
              hold_fall_cyc, last_write_cyc);
        check(start_cnt == 1, "R7", "start pulses", start_cnt, 1);
        host_write(9, 24'h555555, 1'b1);    // R9
        repeat (3) @(negedge clk);
        check(words_seen == 5, "R9", "forwarded writes", words_seen, 5);
        check(exp_q.size() == 0, "R9", "host writes unmatched", exp_q.size(), 0);

        // no-load codes
        run_no_boot(3'b011);
        run_no_boot(3'b100);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule